// File: doc/BRIEF.md
# Power-on strap capture and drive link-reset sequencer

This block sits at the start of a bridge that connects a host bus to several serial disk ports. While the active-low bus reset is held low, every register in the block stays at its default value and all outputs read zero. On the first clock edge after reset is released, the block captures three configuration pins once. The first pin selects the operating mode. The second is the active-low 64-bit request pin, which sets the host bus width. The third is a width strap whose value goes to a status register. These values then stay fixed until the next reset.

The captured mode decides how each drive link is first reset. In legacy IDE mode, every port gets one automatic link-reset (COMRESET) pulse of fixed length, starting one cycle after the straps are captured. In direct-port-access mode, nothing happens automatically, so the drives do not all spin up at the same moment. Software then starts each port in turn by writing that port's 4-bit detection-control field. Writing 1 raises the port's link-reset request and keeps it up. Writing 0 drops it. Any other value leaves the request as it is. The block's per-port request output is the OR of the automatic pulse and the software-held request.

Top module: `port_reset_sequencer`

## Requirements
- R1: While `rst_n` is low, `straps_valid_o`, `legacy_mode_o`, `bus64_o`, `status_bus64_o` and every bit of `comreset_o` are 0.
- R2: On the first clock edge with `rst_n` high, `straps_valid_o` rises to 1 and stays 1 until the next reset.
- R3: `legacy_mode_o` takes the value of `mode_strap_i` at that edge: 1 means legacy IDE mode, 0 means direct-port-access mode.
- R4: `bus64_o` is the inverse of the active-low `req64_n_i` at that edge: 1 means a 64-bit host bus, 0 means a 32-bit host bus.
- R5: `status_bus64_o` takes the value of `width_strap_i` at that edge: 1 reports a 64-bit bus, 0 reports a 32-bit bus.
- R6: Changes on the three strap pins after the capture edge have no effect on the latched outputs until the next reset.
- R7: In legacy mode, every bit of `comreset_o` goes high one cycle after `straps_valid_o` rises. It stays high for exactly PULSE_LEN cycles, and this happens once per reset.
- R8: In direct-port-access mode, a bit of `comreset_o` never rises unless a write with detection value 1 to that port was accepted on the previous edge.
- R9: A write (`cfg_we_i` high, port `cfg_port_i`, `cfg_det_i` = 1) made while `straps_valid_o` is high raises that port's `comreset_o` bit from the next cycle, and the bit stays high.
- R10: A write with `cfg_det_i` = 0 clears that port's software-held request from the next cycle.
- R11: A write with any `cfg_det_i` value other than 0 or 1 leaves that port's request unchanged. Any write leaves every other port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low host bus reset; straps are captured at its release |
| mode_strap_i | input | 1 | Mode strap: 1 selects legacy IDE mode, 0 selects direct-port-access mode |
| req64_n_i | input | 1 | Active-low 64-bit request pin |
| width_strap_i | input | 1 | Bus-width strap reported in status: 1 means 64-bit, 0 means 32-bit |
| cfg_we_i | input | 1 | Write strobe for a detection-control field |
| cfg_port_i | input | PORT_W | Port addressed by the write |
| cfg_det_i | input | 4 | Detection-control value being written |
| straps_valid_o | output | 1 | High once the straps have been captured |
| legacy_mode_o | output | 1 | Latched mode: 1 means legacy IDE mode |
| bus64_o | output | 1 | Latched host bus width: 1 means 64-bit |
| status_bus64_o | output | 1 | Latched width bit for the status register |
| comreset_o | output | NUM_PORTS | Per-port link-reset request |

## Verification
The assertions assume that `cfg_port_i` always addresses a port that exists, and that the strap pins and write inputs change only between clock edges, never on the edge itself. The bench drives every input on the falling clock edge and uses only port indices below NUM_PORTS. It sweeps all eight strap combinations and, for each one, every detection value on every port. Write-based checks in legacy mode begin only after the automatic pulse has ended, so the properties about software-driven edges never see the pulse and a write at the same time.

// File: rtl/prs_pkg.sv
package prs_pkg;

    localparam int DET_W = 4;
    localparam logic [DET_W-1:0] DET_HOLD    = 4'd1;
    localparam logic [DET_W-1:0] DET_RELEASE = 4'd0;

    typedef struct packed {
        logic legacy;
        logic bus64;
        logic stat64;
    } strap_t;

    typedef struct packed {
        logic   valid;
        logic   launch;
        strap_t straps;
    } cap_state_t;

endpackage

// File: rtl/prs_strap_capture.sv
module prs_strap_capture
    import prs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   mode_strap_i,
    input  logic   req64_n_i,
    input  logic   width_strap_i,
    output strap_t straps_o,
    output logic   valid_o,
    output logic   launch_o
);

    cap_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.launch = 1'b0;
        if (!st_q.valid) begin
            // first edge after release: the only moment the pins are looked at
            st_d.valid         = 1'b1;
            st_d.launch        = 1'b1;
            st_d.straps.legacy = mode_strap_i;
            st_d.straps.bus64  = ~req64_n_i;
            st_d.straps.stat64 = width_strap_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign straps_o = st_q.straps;
    assign valid_o  = st_q.valid;
    assign launch_o = st_q.launch;

endmodule

// File: rtl/prs_auto_pulse.sv
module prs_auto_pulse #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch_i,
    input  logic legacy_i,
    output logic active_o
);

    localparam int CNT_W = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic [CNT_W-1:0] remaining;
    } pulse_state_t;

    pulse_state_t ps_d, ps_q;

    always_comb begin
        ps_d = ps_q;
        if (launch_i && legacy_i) begin
            ps_d.remaining = CNT_W'(PULSE_LEN);
        end else if (ps_q.remaining != '0) begin
            ps_d.remaining = ps_q.remaining - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else begin
            ps_q <= ps_d;
        end
    end

    assign active_o = (ps_q.remaining != '0);

endmodule

// File: rtl/prs_det_ctrl.sv
module prs_det_ctrl
    import prs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_i,
    input  logic [DET_W-1:0] det_i,
    output logic             hold_o
);

    typedef struct packed {
        logic hold;
    } det_state_t;

    det_state_t ds_d, ds_q;

    always_comb begin
        ds_d = ds_q;
        if (sel_i) begin
            if (det_i == DET_HOLD) begin
                ds_d.hold = 1'b1;
            end else if (det_i == DET_RELEASE) begin
                ds_d.hold = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ds_q <= '0;
        end else begin
            ds_q <= ds_d;
        end
    end

    assign hold_o = ds_q.hold;

endmodule

// File: rtl/port_reset_sequencer.sv
module port_reset_sequencer
    import prs_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PULSE_LEN = 16,
    parameter int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_strap_i,
    input  logic                 req64_n_i,
    input  logic                 width_strap_i,
    input  logic                 cfg_we_i,
    input  logic [PORT_W-1:0]    cfg_port_i,
    input  logic [DET_W-1:0]     cfg_det_i,
    output logic                 straps_valid_o,
    output logic                 legacy_mode_o,
    output logic                 bus64_o,
    output logic                 status_bus64_o,
    output logic [NUM_PORTS-1:0] comreset_o
);

    strap_t               straps;
    logic                 valid;
    logic                 launch;
    logic                 auto_active;
    logic [NUM_PORTS-1:0] sw_hold;

    prs_strap_capture u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_strap_i (mode_strap_i),
        .req64_n_i    (req64_n_i),
        .width_strap_i(width_strap_i),
        .straps_o     (straps),
        .valid_o      (valid),
        .launch_o     (launch)
    );

    prs_auto_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch_i(launch),
        .legacy_i(straps.legacy),
        .active_o(auto_active)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic sel;
        assign sel = cfg_we_i && valid && (cfg_port_i == PORT_W'(p));

        prs_det_ctrl u_det (
            .clk   (clk),
            .rst_n (rst_n),
            .sel_i (sel),
            .det_i (cfg_det_i),
            .hold_o(sw_hold[p])
        );

        assign comreset_o[p] = auto_active | sw_hold[p];
    end

    assign straps_valid_o = valid;
    assign legacy_mode_o  = straps.legacy;
    assign bus64_o        = straps.bus64;
    assign status_bus64_o = straps.stat64;

endmodule

// File: rtl/prs_checker.sv
module prs_checker
    import prs_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_we_i,
    input logic [PORT_W-1:0]    cfg_port_i,
    input logic [DET_W-1:0]     cfg_det_i,
    input logic                 straps_valid_o,
    input logic                 legacy_mode_o,
    input logic                 bus64_o,
    input logic                 status_bus64_o,
    input logic [NUM_PORTS-1:0] comreset_o
);

    // R1: everything quiet while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!straps_valid_o && comreset_o == '0 && !legacy_mode_o
                                      && !bus64_o && !status_bus64_o)
                else $error("reset outputs not at default");
        end
    end

    p_valid_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        straps_valid_o |=> straps_valid_o);

    p_straps_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (straps_valid_o && $past(straps_valid_o))
            |-> $stable({legacy_mode_o, bus64_o, status_bus64_o}));

    p_legacy_launch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(straps_valid_o) && legacy_mode_o) |=> (&comreset_o));

    p_det_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (straps_valid_o && cfg_we_i && cfg_det_i == DET_HOLD && int'(cfg_port_i) < NUM_PORTS)
            |=> comreset_o[$past(cfg_port_i)]);

    p_det_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (straps_valid_o && !legacy_mode_o && cfg_we_i && cfg_det_i == DET_RELEASE
         && int'(cfg_port_i) < NUM_PORTS)
            |=> !comreset_o[$past(cfg_port_i)]);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        p_dpa_no_spont_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(comreset_o[p]) && !legacy_mode_o)
                |-> $past(cfg_we_i && cfg_det_i == DET_HOLD && cfg_port_i == PORT_W'(p)));
    end

endmodule

bind port_reset_sequencer prs_checker #(
    .NUM_PORTS(NUM_PORTS),
    .PORT_W   (PORT_W)
) u_prs_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we_i      (cfg_we_i),
    .cfg_port_i    (cfg_port_i),
    .cfg_det_i     (cfg_det_i),
    .straps_valid_o(straps_valid_o),
    .legacy_mode_o (legacy_mode_o),
    .bus64_o       (bus64_o),
    .status_bus64_o(status_bus64_o),
    .comreset_o    (comreset_o)
);

// File: tb/tb_port_reset_sequencer.sv
`timescale 1ns/1ps
module tb_port_reset_sequencer;

    localparam int NP   = 4;
    localparam int PLEN = 16;
    localparam int PW   = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_strap_i = 1'b1;
    logic          req64_n_i = 1'b1;
    logic          width_strap_i = 1'b1;
    logic          cfg_we_i = 1'b0;
    logic [PW-1:0] cfg_port_i = '0;
    logic [3:0]    cfg_det_i = '0;
    logic          straps_valid_o, legacy_mode_o, bus64_o, status_bus64_o;
    logic [NP-1:0] comreset_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    port_reset_sequencer #(.NUM_PORTS(NP), .PULSE_LEN(PLEN)) dut (
        .clk(clk), .rst_n(rst_n), .mode_strap_i(mode_strap_i), .req64_n_i(req64_n_i),
        .width_strap_i(width_strap_i), .cfg_we_i(cfg_we_i), .cfg_port_i(cfg_port_i),
        .cfg_det_i(cfg_det_i), .straps_valid_o(straps_valid_o), .legacy_mode_o(legacy_mode_o),
        .bus64_o(bus64_o), .status_bus64_o(status_bus64_o), .comreset_o(comreset_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sw_write(input int port, input int det);
        @(negedge clk);
        cfg_we_i   = 1'b1;
        cfg_port_i = PW'(port);
        cfg_det_i  = 4'(det);
        @(negedge clk);
        cfg_we_i   = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int combo = 0; combo < 8; combo++) begin
            logic m, r, w;
            logic [NP-1:0] exp_hold;
            int hi_cnt [NP];
            m = combo[0]; r = combo[1]; w = combo[2];
            exp_hold = '0;

            // reset phase, straps applied while held
            @(negedge clk);
            rst_n = 1'b0;
            mode_strap_i = m; req64_n_i = r; width_strap_i = w;
            repeat (3) @(negedge clk);
            chk("R1 valid", straps_valid_o, 0);
            chk("R1 flags", {legacy_mode_o, bus64_o, status_bus64_o}, 0);
            chk("R1 comreset", comreset_o, 0);
            rst_n = 1'b1;
            @(negedge clk);
            chk("R2 valid", straps_valid_o, 1);
            chk("R3 mode", legacy_mode_o, m);
            chk("R4 bus64", bus64_o, !r);
            chk("R5 status", status_bus64_o, w);
            chk("R7 idle at capture", comreset_o, 0);

            // flip straps: must be ignored
            mode_strap_i = !m; req64_n_i = !r; width_strap_i = !w;

            foreach (hi_cnt[p]) hi_cnt[p] = 0;
            for (int s = 0; s < PLEN + 10; s++) begin
                @(negedge clk);
                if (s == 0) chk("R7 start", comreset_o, m ? {NP{1'b1}} : 0);
                for (int p = 0; p < NP; p++) if (comreset_o[p]) hi_cnt[p]++;
            end
            for (int p = 0; p < NP; p++) begin
                if (m) chk("R7 pulse length", hi_cnt[p], PLEN);
                else   chk("R8 no auto reset", hi_cnt[p], 0);
            end
            chk("R6 mode frozen", legacy_mode_o, m);
            chk("R6 bus64 frozen", bus64_o, !r);
            chk("R6 status frozen", status_bus64_o, w);
            chk("R2 valid held", straps_valid_o, 1);

            // detection-control sweep on every port
            for (int p = 0; p < NP; p++) begin
                for (int v = 0; v < 16; v++) begin
                    sw_write(p, (v + 1) % 16);
                    if ((v + 1) % 16 == 1) exp_hold[p] = 1'b1;
                    else if ((v + 1) % 16 == 0) exp_hold[p] = 1'b0;
                    if ((v + 1) % 16 == 1) chk("R9 set", comreset_o, exp_hold);
                    else if ((v + 1) % 16 == 0) chk("R10 clear", comreset_o, exp_hold);
                    else chk("R11 unchanged", comreset_o, exp_hold);
                end
                // held request, then other codes leave it set
                sw_write(p, 1);
                exp_hold[p] = 1'b1;
                chk("R9 set again", comreset_o, exp_hold);
                sw_write(p, 9);
                chk("R11 held through other code", comreset_o, exp_hold);
                repeat (5) @(negedge clk);
                chk("R9 stays high", comreset_o, exp_hold);
                if (p % 2 == 1) begin
                    sw_write(p, 0);
                    exp_hold[p] = 1'b0;
                    chk("R10 release", comreset_o, exp_hold);
                end
            end
            chk("R6 mode after writes", legacy_mode_o, m);
        end

        // final reset with requests still held
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 comreset cleared by reset", comreset_o, 0);
        chk("R1 valid cleared by reset", straps_valid_o, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule